// File: doc/BRIEF.md
# Combined PC and Status Register Writeback

This block is the final stage for data-processing instructions in a processor with a 26-bit address space. In that processor the program counter and the status word share one 32-bit register, R15. The block holds the live contents of R15 and decides, for each retired instruction, which parts of R15 change. It also decides whether a general register is written. The ALU, the shifter and the instruction decoder sit upstream. They present one finished operation per cycle on the `op_*` and `alu_*` inputs.

The packed R15 word has these fields:

| Bits | Field |
|------|-------|
| 31–28 | N, Z, C, V condition flags |
| 27 | interrupt disable |
| 26 | fast interrupt disable |
| 25–2 | word address of the PC |
| 1–0 | mode |

Mode `00` is user mode. Every other mode value is privileged. Reset enters mode `11`.

Instructions whose destination is not R15 behave as follows. The result goes to the register file through a combinational write port. When the set-status bit is on, the four ALU flags are latched.

When R15 is the destination, the result word itself is the source, and the mode decides how far it reaches:
- With set-status clear, only the PC changes.
- With set-status on, the condition flags are loaded from the result.
- In a privileged mode, the set-status case also loads the interrupt masks and the mode from the result.
- In user mode, the interrupt masks and the mode are protected and keep their values.
- Compare and test operations never write the PC. They can still update the status through R15.

Every PC write raises a one-cycle flush pulse.

Top module: `r15_writeback`

## Requirements
- R1: On reset, the outputs are cleared as follows: PC 0, flags 0, both interrupt masks 1, mode `11`, flush 0.
- R2: `rf_we` is high in the same cycle as an accepted non-compare operation whose destination is not 15. When it is high, `rf_waddr` equals the destination index and `rf_wdata` equals the ALU result. A compare/test operation never raises `rf_we`.
- R3: An accepted operation with destination other than 15 and set-status on loads `nzcv` from `alu_nzcv` (N in bit 3, V in bit 0) at the next clock edge. This holds for compare/test operations too. The PC, the masks and the mode stay unchanged.
- R4: An accepted operation with destination 15 and set-status on loads `nzcv` from result bits 31–28 at the next edge. The ALU flags are ignored in this case.
- R5: In user mode (`00`), an operation with destination 15 and set-status on leaves `irq_off`, `fiq_off` and `mode` unchanged.
- R6: In a privileged mode, the same operation loads `irq_off` from result bit 27, `fiq_off` from bit 26 and `mode` from bits 1–0.
- R7: A non-compare operation with destination 15 and set-status clear loads `pc_word` from result bits 25–2. It leaves flags, masks and mode unchanged.
- R8: A compare/test operation with destination 15 leaves `pc_word` unchanged and raises no flush. With set-status on, it updates the status bits as R4–R6 describe.
- R9: `flush` is high for exactly the one cycle after each edge that wrote the PC, and is low in all other cycles.
- R10: A mode written through R15 is visible on `mode` after the same edge. The protection rule for the next operation uses the new mode.
- R11: When `op_valid` is low, no state changes and `rf_we` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation retires this cycle |
| op_dest | input | 4 | Destination register index |
| op_set_status | input | 1 | Set-status bit of the instruction |
| op_compare | input | 1 | Operation is a compare/test (no register result) |
| alu_result | input | 32 | ALU result word |
| alu_nzcv | input | 4 | ALU flags, N in bit 3 to V in bit 0 |
| rf_we | output | 1 | General register write enable |
| rf_waddr | output | 4 | General register write index |
| rf_wdata | output | 32 | General register write data |
| pc_word | output | 24 | Current PC word address (R15 bits 25–2) |
| nzcv | output | 4 | Current condition flags |
| irq_off | output | 1 | Interrupt disable bit |
| fiq_off | output | 1 | Fast interrupt disable bit |
| mode | output | 2 | Current processor mode |
| flush | output | 1 | One-cycle pipeline flush after a PC write |

## Verification
The bench concentrates on R15 destinations where mode, set-status and compare class interact:
- A user-mode status write must not touch the masks or the mode. A design that ignored the protection would let user code disable interrupts or escalate its privilege.
- A compare aimed at R15 must not touch the PC and must not flush. A design that got this wrong would branch on a test instruction.
- A write with set-status clear must leave every status bit alone.
- A privileged write that drops into user mode is followed at once by a write that tries to restore privilege. This catches protection that lags the mode by a cycle.
- The flag source is switched between ALU flags and result bits. A crossed source shows up as wrong flags whenever the two disagree, which the random stimulus makes the usual case.

// File: rtl/r15_writeback.sv
module r15_writeback #(
  parameter int          IDX_W     = 4,
  parameter int          PC_IDX    = 15,
  parameter logic [1:0]  USER_MODE = 2'b00,
  parameter logic [1:0]  RST_MODE  = 2'b11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [IDX_W-1:0] op_dest,
  input  logic             op_set_status,
  input  logic             op_compare,
  input  logic [31:0]      alu_result,
  input  logic [3:0]       alu_nzcv,
  output logic             rf_we,
  output logic [IDX_W-1:0] rf_waddr,
  output logic [31:0]      rf_wdata,
  output logic [23:0]      pc_word,
  output logic [3:0]       nzcv,
  output logic             irq_off,
  output logic             fiq_off,
  output logic [1:0]       mode,
  output logic             flush
);
  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

  logic to_pc, pc_write, psr_from_res, flags_from_alu, privileged;

  assign to_pc          = op_valid && (op_dest == PC_SEL);
  assign pc_write       = to_pc && !op_compare;
  assign psr_from_res   = to_pc && op_set_status;
  assign flags_from_alu = op_valid && !to_pc && op_set_status;
  assign privileged     = (mode != USER_MODE);

  assign rf_we    = op_valid && !op_compare && (op_dest != PC_SEL);
  assign rf_waddr = op_dest;
  assign rf_wdata = alu_result;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_word <= '0;
      nzcv    <= '0;
      irq_off <= 1'b1;
      fiq_off <= 1'b1;
      mode    <= RST_MODE;
      flush   <= 1'b0;
    end else begin
      flush <= pc_write;
      if (pc_write)
        pc_word <= alu_result[25:2];
      if (psr_from_res) begin
        nzcv <= alu_result[31:28];
        if (privileged) begin
          irq_off <= alu_result[27];
          fiq_off <= alu_result[26];
          mode    <= alu_result[1:0];
        end
      end else if (flags_from_alu) begin
        nzcv <= alu_nzcv;
      end
    end
  end
endmodule

module r15_writeback_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [3:0]  op_dest,
  input logic        op_set_status,
  input logic        op_compare,
  input logic        rf_we,
  input logic [23:0] pc_word,
  input logic [3:0]  nzcv,
  input logic        irq_off,
  input logic        fiq_off,
  input logic [1:0]  mode,
  input logic        flush
);
  AST_CMP_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_compare) |-> !rf_we); // R2
  AST_USER_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_dest == 4'd15 && mode == 2'b00) |=> $stable({irq_off, fiq_off, mode})); // R5
  AST_NOS_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_dest == 4'd15 && !op_set_status) |=> $stable({nzcv, irq_off, fiq_off, mode})); // R7
  AST_CMP_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_compare) |=> ($stable(pc_word) && !flush)); // R8
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(op_valid && op_dest == 4'd15 && !op_compare)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable({pc_word, nzcv, irq_off, fiq_off, mode})); // R11
  AST_IDLE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !rf_we); // R11
endmodule

bind r15_writeback r15_writeback_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dest(op_dest),
  .op_set_status(op_set_status), .op_compare(op_compare), .rf_we(rf_we),
  .pc_word(pc_word), .nzcv(nzcv), .irq_off(irq_off), .fiq_off(fiq_off),
  .mode(mode), .flush(flush)
);

// File: tb/tb_r15_writeback.sv
module tb_r15_writeback;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_set_status = 1'b0, op_compare = 1'b0;
  logic [3:0] op_dest = '0;
  logic [31:0] alu_result = '0;
  logic [3:0] alu_nzcv = '0;
  logic rf_we, irq_off, fiq_off, flush;
  logic [3:0] rf_waddr, nzcv;
  logic [31:0] rf_wdata;
  logic [23:0] pc_word;
  logic [1:0] mode;

  int checks = 0, fails = 0;
  logic done = 1'b0;

  logic [23:0] e_pc;
  logic [3:0]  e_nzcv;
  logic        e_irq, e_fiq, e_flush;
  logic [1:0]  e_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  r15_writeback dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dest(op_dest),
    .op_set_status(op_set_status), .op_compare(op_compare), .alu_result(alu_result),
    .alu_nzcv(alu_nzcv), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .pc_word(pc_word), .nzcv(nzcv), .irq_off(irq_off), .fiq_off(fiq_off),
    .mode(mode), .flush(flush)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_rf_we(input logic v, input logic [3:0] d, input logic c);
    return v && !c && d != 4'd15;
  endfunction

  task automatic model(input logic v, input logic [3:0] d, input logic s, input logic c,
                       input logic [31:0] r, input logic [3:0] f);
    logic priv;
    priv = (e_mode != 2'b00);
    e_flush = v && d == 4'd15 && !c;
    if (e_flush) e_pc = r[25:2];
    if (v && d == 4'd15 && s) begin
      e_nzcv = r[31:28];
      if (priv) begin e_irq = r[27]; e_fiq = r[26]; e_mode = r[1:0]; end
    end else if (v && s) e_nzcv = f;
  endtask

  task automatic step(input logic v, input logic [3:0] d, input logic s, input logic c,
                      input logic [31:0] r, input logic [3:0] f, input string req);
    @(negedge clk);
    op_valid = v; op_dest = d; op_set_status = s; op_compare = c; alu_result = r; alu_nzcv = f;
    #1;
    chk(exp_rf_we(v, d, c) ? "R2" : (v ? req : "R11"), "rf_we", 64'(rf_we), 64'(exp_rf_we(v, d, c)));
    if (rf_we) begin
      chk("R2", "rf_waddr", 64'(rf_waddr), 64'(d));
      chk("R2", "rf_wdata", 64'(rf_wdata), 64'(r));
    end
    model(v, d, s, c, r, f);
    @(posedge clk); #1;
    chk(req, "pc_word", 64'(pc_word), 64'(e_pc));
    chk(req, "nzcv", 64'(nzcv), 64'(e_nzcv));
    chk(req, "irq/fiq/mode", 64'({irq_off, fiq_off, mode}), 64'({e_irq, e_fiq, e_mode}));
    chk("R9", "flush", 64'(flush), 64'(e_flush));
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pc_word", 64'(pc_word), 64'h0);
    chk("R1", "nzcv", 64'(nzcv), 64'h0);
    chk("R1", "irq/fiq/mode", 64'({irq_off, fiq_off, mode}), 64'b1111);
    chk("R1", "flush", 64'(flush), 64'h0);
    e_pc = '0; e_nzcv = '0; e_irq = 1'b1; e_fiq = 1'b1; e_mode = 2'b11; e_flush = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    step(1, 4'd3, 1, 0, 32'h1234_5678, 4'b1010, "R3");
    step(1, 4'd15, 0, 0, 32'hF000_0ABC, 4'b0101, "R7");
    step(1, 4'd15, 1, 0, 32'h5800_0101, 4'b1111, "R6");
    step(1, 4'd15, 1, 0, 32'hA000_0010, 4'b0000, "R4");
    step(1, 4'd15, 1, 0, 32'h3C00_0000, 4'b0000, "R10");
    step(1, 4'd15, 1, 0, 32'h9C00_0003, 4'b0000, "R5");
    step(1, 4'd15, 1, 1, 32'h7C00_FFF3, 4'b0000, "R8");
    step(1, 4'd7, 1, 1, 32'hFFFF_FFFF, 4'b0110, "R3");
    step(0, 4'd15, 1, 0, 32'hFFFF_FFFF, 4'b1111, "R11");
    step(1, 4'd2, 0, 0, 32'hDEAD_BEEF, 4'b1111, "R2");

    repeat (3000) begin
      logic v, s, c;
      logic [3:0] d;
      string req;
      v = ($urandom % 8) != 0;
      d = ($urandom % 2) ? 4'd15 : 4'($urandom % 15);
      s = $urandom % 2;
      c = ($urandom % 4) == 0;
      if (!v) req = "R11";
      else if (d == 4'd15 && c) req = "R8";
      else if (d == 4'd15 && !s) req = "R7";
      else if (d == 4'd15) req = (e_mode == 2'b00) ? "R5" : "R6";
      else req = s ? "R3" : "R2";
      step(v, d, s, c, $urandom, 4'($urandom), req);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule